// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Access Permissions

This block caches recent virtual-to-physical page translations. A lookup request carries a virtual address and an access kind (read or write). The virtual page number is compared against every stored tag at once. The block checks the matching entry's read or write permission. It then joins the entry's physical page number with the untouched page offset. The result is registered, so every lookup is answered in the clock cycle after the request. A miss is reported to the surrounding logic, which is expected to fetch the translation elsewhere and install it through the fill port. Only translations of pages that are resident in memory are meant to be installed.

Each entry holds a valid flag, a virtual page tag, a physical page number and separate read-allowed and write-allowed bits. A fill goes to the lowest-numbered empty entry. Once the table is full, a rotating victim pointer picks the entry to overwrite. A fill whose tag is already present overwrites that entry in place, so a tag is never held twice. A flush strobe empties the table on a process switch.

Top module: `tlb_xlate`

## Requirements
- R1: A request (req_valid=1) whose page number matches a valid entry whose permission for the access kind is set gives, one cycle later, rsp_valid=1, rsp_hit=1, rsp_miss=0, rsp_viol=0 and rsp_pa = {stored physical page number, the request's page offset}. The page offset is the low OFF_W address bits.
- R2: A request whose page number matches no valid entry gives rsp_miss=1, rsp_hit=0, rsp_viol=0 and rsp_pa=0 one cycle later.
- R3: A write request (req_write=1) that matches an entry whose write-allowed bit is clear gives rsp_viol=1, rsp_hit=0, rsp_miss=0 and rsp_pa=0.
- R4: A read request (req_write=0) that matches an entry whose read-allowed bit is clear gives rsp_viol=1, rsp_hit=0, rsp_miss=0 and rsp_pa=0.
- R5: A flush invalidates every entry, and later lookups of any earlier translation miss.
- R6: When flush and fill_en are high in the same cycle, the flush wins and the fill's translation is not installed.
- R7: Fills into a table that is not full occupy empty entries from index 0 upward. ENTRIES distinct fills make a full table in which every installed page hits.
- R8: A fill of a new tag into a full table replaces the entry at the victim pointer. The pointer starts at index 0 after reset or flush and moves up by one, wrapping, after each such replacement.
- R9: A fill whose tag is already valid overwrites that entry's page number and permissions in place. No other entry is displaced and the victim pointer does not move.
- R10: A lookup in the same cycle as a fill sees the table as it was before that fill.
- R11: After reset no entry is valid, and rsp_valid, rsp_hit, rsp_miss and rsp_viol are 0. In any cycle after a cycle without a request, rsp_valid and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | VPN_W+OFF_W | Virtual address of the request |
| req_write | input | 1 | Access kind: 1 write, 0 read |
| fill_en | input | 1 | Install a translation this cycle |
| fill_vpn | input | VPN_W | Virtual page tag to install |
| fill_ppn | input | PPN_W | Physical page number to install |
| fill_rd_ok | input | 1 | Read permission of the new entry |
| fill_wr_ok | input | 1 | Write permission of the new entry |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present (one cycle after a request) |
| rsp_pa | output | PPN_W+OFF_W | Physical address, 0 unless hit |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_viol | output | 1 | Entry matched but access kind not permitted |

## Verification
The bench keeps its own table model and replacement pointer, and compares every response against it through a scoreboard queue. The corner cases it targets are these:
- A matching tag with the wrong permission. A design that ignored permissions would report a hit.
- A fill in the same cycle as a lookup. A design that forwarded fill data would hit where a miss is due.
- A flush that coincides with a fill. A design with the wrong priority would keep the new entry.
- Rotation of the victim pointer across successive replacements in a full table. A wrong pointer evicts the wrong page, and a later lookup then misses or hits where it should not.
- A refill of an already-held tag in a full table. A design that allocated a fresh entry would evict an unrelated page, or would move the pointer so the next replacement lands on the wrong index.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef struct packed {
      logic rd_ok;
      logic wr_ok;
   } tlb_perm_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 30
) (
   input  logic [ENTRIES-1:0]            valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
   input  logic [VPN_W-1:0]              key,
   output logic [ENTRIES-1:0]            match
);
   genvar g;
   generate
      for (g = 0; g < ENTRIES; g++) begin : g_cmp
         assign match[g] = valid[g] && (tags[g] == key);
      end
   endgenerate
endmodule

// File: rtl/tlb_enc.sv
module tlb_enc #(
   parameter int ENTRIES = 32,
   parameter int IW      = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] vec,
   output logic [IW-1:0]      idx,
   output logic               any
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (vec[i]) idx = idx | IW'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int ENTRIES = 32,
   parameter int IW      = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [ENTRIES-1:0] valid,
   input  logic               advance,
   output logic [IW-1:0]      victim,
   output logic               full
);
   localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

   logic [IW-1:0] ptr;
   logic [IW-1:0] first_free;

   always_comb begin
      first_free = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid[i]) first_free = IW'(i);
      end
   end

   assign full   = &valid;
   assign victim = full ? ptr : first_free;

   always_ff @(posedge clk) begin
      if (!rst_n || flush) ptr <= '0;
      else if (advance)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   // R8: the pointer moves only on a replacement into a full table
   assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !flush) |=> $stable(ptr));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 32,
   parameter int VPN_W   = 30,
   parameter int PPN_W   = 21,
   parameter int OFF_W   = 13
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic [VPN_W+OFF_W-1:0] req_va,
   input  logic                   req_write,
   input  logic                   fill_en,
   input  logic [VPN_W-1:0]       fill_vpn,
   input  logic [PPN_W-1:0]       fill_ppn,
   input  logic                   fill_rd_ok,
   input  logic                   fill_wr_ok,
   input  logic                   flush,
   output logic                   rsp_valid,
   output logic [PPN_W+OFF_W-1:0] rsp_pa,
   output logic                   rsp_hit,
   output logic                   rsp_miss,
   output logic                   rsp_viol
);
   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   generate
      if (ENTRIES < 2)  begin : g_bad_n   $error("ENTRIES must be at least 2"); end
      if (VPN_W < 1)    begin : g_bad_vpn $error("VPN_W must be positive");     end
      if (PPN_W < 1)    begin : g_bad_ppn $error("PPN_W must be positive");     end
      if (OFF_W < 1)    begin : g_bad_off $error("OFF_W must be positive");     end
   endgenerate

   logic [ENTRIES-1:0]            ent_valid;
   logic [ENTRIES-1:0][VPN_W-1:0] ent_tag;
   logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
   tlb_perm_t [ENTRIES-1:0]       ent_perm;

   // ---------------- lookup path ----------------
   logic [VPN_W-1:0]   lk_vpn;
   logic [OFF_W-1:0]   lk_off;
   logic [ENTRIES-1:0] lk_match;
   logic [IW-1:0]      lk_idx;
   logic               lk_any;
   tlb_perm_t          lk_perm;
   logic               lk_allowed;

   assign lk_vpn = req_va[VPN_W+OFF_W-1:OFF_W];
   assign lk_off = req_va[OFF_W-1:0];

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam_lk (
      .valid(ent_valid), .tags(ent_tag), .key(lk_vpn), .match(lk_match));
   tlb_enc #(.ENTRIES(ENTRIES), .IW(IW)) u_enc_lk (
      .vec(lk_match), .idx(lk_idx), .any(lk_any));

   assign lk_perm    = ent_perm[lk_idx];
   assign lk_allowed = req_write ? lk_perm.wr_ok : lk_perm.rd_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_viol  <= 1'b0;
         rsp_pa    <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid && lk_any && lk_allowed;
         rsp_miss  <= req_valid && !lk_any;
         rsp_viol  <= req_valid && lk_any && !lk_allowed;
         rsp_pa    <= (req_valid && lk_any && lk_allowed) ?
                      {ent_ppn[lk_idx], lk_off} : '0;
      end
   end

   // ---------------- fill path ----------------
   logic [ENTRIES-1:0] fl_match;
   logic [IW-1:0]      fl_hit_idx;
   logic               fl_dup;
   logic [IW-1:0]      vic_idx;
   logic               tbl_full;
   logic               fl_go;
   logic [IW-1:0]      fill_idx;

   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_cam_fl (
      .valid(ent_valid), .tags(ent_tag), .key(fill_vpn), .match(fl_match));
   tlb_enc #(.ENTRIES(ENTRIES), .IW(IW)) u_enc_fl (
      .vec(fl_match), .idx(fl_hit_idx), .any(fl_dup));

   assign fl_go    = fill_en && !flush;
   assign fill_idx = fl_dup ? fl_hit_idx : vic_idx;

   tlb_victim #(.ENTRIES(ENTRIES), .IW(IW)) u_victim (
      .clk(clk), .rst_n(rst_n), .flush(flush), .valid(ent_valid),
      .advance(fl_go && !fl_dup && tbl_full),
      .victim(vic_idx), .full(tbl_full));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_valid <= '0;
         ent_tag   <= '0;
         ent_ppn   <= '0;
         ent_perm  <= '0;
      end else if (flush) begin
         ent_valid <= '0;
      end else if (fill_en) begin
         ent_valid[fill_idx]      <= 1'b1;
         ent_tag[fill_idx]        <= fill_vpn;
         ent_ppn[fill_idx]        <= fill_ppn;
         ent_perm[fill_idx].rd_ok <= fill_rd_ok;
         ent_perm[fill_idx].wr_ok <= fill_wr_ok;
      end
   end

   // ---------------- assertions ----------------
   // R9: a tag is never held by more than one entry
   assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_match));
   // R5: flush leaves no valid entry
   assert_flush_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ent_valid == '0));
   // R6: a fill under flush installs nothing
   assert_flush_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && fill_en) |=> !(|fl_match));
   // R1: a response of exactly one kind follows every request
   assert_one_outcome_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_valid && $onehot({rsp_hit, rsp_miss, rsp_viol})));
   // R11: no response without a request
   assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !(rsp_valid || rsp_hit || rsp_miss || rsp_viol));
   // R1: the page offset passes through unchanged on a hit
   assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && lk_any && lk_allowed) |=> (rsp_pa[OFF_W-1:0] == $past(lk_off)));
   // R7: a fill outside flush leaves its tag present
   assert_fill_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fl_go |=> (|fl_match || $past(fill_vpn) != fill_vpn || flush));
endmodule

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
   localparam int N     = 32;
   localparam int VPN_W = 30;
   localparam int PPN_W = 21;
   localparam int OFF_W = 13;

   typedef struct {
      logic [PPN_W+OFF_W-1:0] pa;
      logic hit, miss, viol;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [VPN_W+OFF_W-1:0] req_va = '0;
   logic fill_en = 1'b0, fill_rd_ok = 1'b0, fill_wr_ok = 1'b0, flush = 1'b0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [PPN_W-1:0] fill_ppn = '0;
   logic rsp_valid, rsp_hit, rsp_miss, rsp_viol;
   logic [PPN_W+OFF_W-1:0] rsp_pa;

   always #2 clk = ~clk;

   tlb_xlate #(.ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_tlb_xlate (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_write(req_write), .fill_en(fill_en), .fill_vpn(fill_vpn),
      .fill_ppn(fill_ppn), .fill_rd_ok(fill_rd_ok), .fill_wr_ok(fill_wr_ok),
      .flush(flush), .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_hit(rsp_hit),
      .rsp_miss(rsp_miss), .rsp_viol(rsp_viol));

   int n_chk = 0, n_bad = 0;
   bit done = 0;
   exp_t sb[$];

   // bench model of the table
   logic             m_v [N];
   logic [VPN_W-1:0] m_tag [N];
   logic [PPN_W-1:0] m_ppn [N];
   logic             m_rd [N], m_wr [N];
   int               m_ptr;

   function automatic int m_find(logic [VPN_W-1:0] vpn);
      for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == vpn) return i;
      return -1;
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // one cycle of stimulus; called right after a falling edge
   task automatic step(input bit lk, input logic [VPN_W-1:0] vpn,
                       input logic [OFF_W-1:0] off, input bit wr,
                       input bit fl, input logic [VPN_W-1:0] fvpn,
                       input logic [PPN_W-1:0] fppn, input bit frd, input bit fwr,
                       input bit fs, input string tag);
      exp_t e;
      int k;
      req_valid = lk; req_va = {vpn, off}; req_write = wr;
      fill_en = fl; fill_vpn = fvpn; fill_ppn = fppn;
      fill_rd_ok = frd; fill_wr_ok = fwr; flush = fs;
      if (lk) begin
         k = m_find(vpn);
         e.tag = tag; e.pa = '0; e.hit = 0; e.miss = 0; e.viol = 0;
         if (k < 0) e.miss = 1;
         else if (wr ? m_wr[k] : m_rd[k]) begin e.hit = 1; e.pa = {m_ppn[k], off}; end
         else e.viol = 1;
         sb.push_back(e);
      end
      if (fs) begin
         for (int i = 0; i < N; i++) m_v[i] = 0;
         m_ptr = 0;
      end else if (fl) begin
         k = m_find(fvpn);
         if (k < 0) for (int i = N - 1; i >= 0; i--) if (!m_v[i]) k = i;
         if (k < 0) begin k = m_ptr; m_ptr = (m_ptr + 1) % N; end
         m_v[k] = 1; m_tag[k] = fvpn; m_ppn[k] = fppn; m_rd[k] = frd; m_wr[k] = fwr;
      end
      @(negedge clk);
      req_valid = 0; fill_en = 0; flush = 0;
   endtask

   task automatic look(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                       input bit wr, input string tag);
      step(1, vpn, off, wr, 0, '0, '0, 0, 0, 0, tag);
   endtask

   task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                       input bit rd, input bit wr);
      step(0, '0, '0, 0, 1, vpn, ppn, rd, wr, 0, "");
   endtask

   // monitor: compare each response with the oldest expectation
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         n_chk++;
         if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL R11 unexpected response pa=%h exp none", rsp_pa);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rsp_pa !== e.pa || rsp_hit !== e.hit || rsp_miss !== e.miss ||
                rsp_viol !== e.viol) begin
               n_bad++;
               $display("FAIL %s pa=%h h/m/v=%b%b%b exp pa=%h h/m/v=%b%b%b", e.tag,
                        rsp_pa, rsp_hit, rsp_miss, rsp_viol, e.pa, e.hit, e.miss, e.viol);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired act running exp finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_tag[i] = '0; m_ppn[i] = '0; m_rd[i] = 0; m_wr[i] = 0; end
      m_ptr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      n_chk++;
      if (rsp_valid !== 0 || rsp_hit !== 0 || rsp_miss !== 0 || rsp_viol !== 0) begin
         n_bad++;
         $display("FAIL R11 reset flags=%b%b%b%b exp 0000", rsp_valid, rsp_hit, rsp_miss, rsp_viol);
      end
      look(30'd5, 13'h0AB, 0, "R11 empty table miss");
      look(30'd5, 13'h0AB, 1, "R2 miss");
      fill(30'd5, 21'h12345, 1, 1);
      look(30'd5, 13'h1FFF, 0, "R1 read hit");
      look(30'd5, 13'h0000, 1, "R1 write hit");
      look(30'd6, 13'h0001, 0, "R2 neighbour miss");
      fill(30'd7, 21'h0ABCD, 1, 0);
      look(30'd7, 13'h0123, 1, "R3 write to read-only");
      look(30'd7, 13'h0123, 0, "R1 read of read-only");
      fill(30'd9, 21'h1F0F0, 0, 1);
      look(30'd9, 13'h0456, 0, "R4 read of write-only");
      look(30'd9, 13'h0456, 1, "R1 write of write-only");
      step(1, 30'd11, 13'h7, 0, 1, 30'd11, 21'h00077, 1, 1, 0, "R10 lookup with fill");
      look(30'd11, 13'h7, 0, "R10 after fill");
      step(0, '0, '0, 0, 0, '0, '0, 0, 0, 1, "");
      look(30'd5, 13'h1, 0, "R5 flushed");
      look(30'd11, 13'h1, 1, "R5 flushed");
      step(0, '0, '0, 0, 1, 30'd20, 21'h00020, 1, 1, 1, "");
      look(30'd20, 13'h2, 0, "R6 flush beats fill");
      for (int i = 0; i < N; i++) fill(30'(100 + i), 21'(16'hA000 + i), 1, 1);
      for (int i = 0; i < N; i++) look(30'(100 + i), 13'(i), 0, "R7 full table hit");
      fill(30'd300, 21'h00300, 1, 1);
      look(30'd100, 13'h3, 0, "R8 first victim evicted");
      look(30'd101, 13'h3, 0, "R8 second entry kept");
      look(30'd300, 13'h3, 0, "R8 new entry hit");
      fill(30'd301, 21'h00301, 1, 1);
      look(30'd101, 13'h4, 0, "R8 pointer advanced");
      fill(30'd110, 21'h1BEEF, 1, 0);
      look(30'd110, 13'h5, 0, "R9 refilled page");
      look(30'd110, 13'h5, 1, "R9 refilled permission");
      for (int i = 2; i < N; i++) look(30'(100 + i), 13'h6, 0, "R9 nothing displaced");
      fill(30'd302, 21'h00302, 1, 1);
      look(30'd102, 13'h8, 0, "R9 pointer unmoved by refill");
      look(30'd103, 13'h8, 0, "R8 next entry kept");
      repeat (3) @(negedge clk);
      if (sb.size() != 0) begin
         n_chk++; n_bad++;
         $display("FAIL R1 missing responses act %0d exp 0", sb.size());
      end
      finish_run();
   end
endmodule